// File: doc/BRIEF.md
# Rectangle Copy Blitter with Raster Operations

The block receives a rectangle copy command as a stream of eight 32-bit words, one word per accepted handshake. Once the eighth word is in, the block walks the destination rectangle one row at a time, top to bottom, and left to right within each row. For each pixel it reads the matching source pixel and the current destination word through a single word-addressed memory port. It then writes back an 8-bit three-operand raster-op combination of the two, with byte enables that cover only that pixel's bytes.

Pixels are 8, 16 or 32 bits wide, and surfaces have a linear layout. On 32-bit pixels the alpha byte and the three colour bytes have separate write enables. While a copy is running the command input is held off. A one-cycle done pulse marks the end of every command, including a command that writes nothing.

Top module: `blit_engine`

## Requirements
- R1: Words are taken only while `cmd_ready_o` is high. The eight words are, in order: flags, control, destination top-left, destination bottom-right, destination base, source top-left, source pitch, source base. From the cycle after the eighth word until the cycle after `done_o`, `cmd_ready_o` stays low and `busy_o` stays high. `done_o` is high for exactly one cycle, and extra words offered while busy are dropped.
- R2: Each coordinate word carries y in bits 31:16 and x in bits 15:0, and the bottom-right corner is exclusive. The byte address of a pixel is base + y*pitch + x*bytes_per_pixel, and the bus carries that address divided by 4. The two low bits of each base are ignored. A rectangle of w by h pixels causes exactly w*h writes, and the source rectangle starts at the source top-left corner.
- R3: The raster-op byte sits in control bits 23:16. Result bit i equals rop[4 + 2*src_i + dst_i]. This makes 0xCC a copy, 0x00 a clear, 0xFF a set, 0x55 a destination invert and 0x66 an XOR.
- R4: Format code 0 in control bits 25:24 selects 8-bit pixels. Each write enables only the byte lane given by the low two address bits.
- R5: Format code 1 selects 16-bit pixels. Each write enables only the two bytes of that pixel's half-word.
- R6: Format code 3 selects 32-bit pixels. Flags bit 1 enables the alpha byte (bits 31:24) and flags bit 0 enables the three colour bytes. With both set, the whole word is written.
- R7: A command whose right edge is not greater than its left edge, or whose bottom edge is not greater than its top edge, writes nothing but still produces one done pulse.
- R8: Both pitches sit in bits 15:0 of their words, in bytes. Their two low bits are ignored.
- R9: Pixels are processed in row-major order. A source that overlaps the destination therefore reads pixels already written earlier in the same command.
- R10: Format code 2 is reserved. Such a command writes nothing but still produces one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| cmd_valid_i | input | 1 | Command word offered |
| cmd_data_i | input | 32 | Command word |
| cmd_ready_o | output | 1 | Command word accepted this cycle when valid |
| busy_o | output | 1 | A command is being executed |
| done_o | output | 1 | One-cycle pulse at the end of a command |
| mem_addr_o | output | 30 | Word address of the memory access |
| mem_rd_o | output | 1 | Read request; data returns on the next cycle |
| mem_wr_o | output | 1 | Write request |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte enables of the write |
| mem_rdata_i | input | 32 | Read data for the previous cycle's read |

## Verification
The bench uses odd x positions in 8-bit and 16-bit formats, where a wrong lane select would damage neighbouring pixels in the same word. It runs each of the five named raster ops, where a swapped operand index would make copy act as a no-op. It masks alpha and colour bytes separately, where reversed enables would overwrite the wrong byte. It supplies pitches with their low bits set, where a design that kept those bits would shift rows by a few bytes.

An overlapped copy shifted one pixel right must smear the first pixel across the row; a right-to-left walk would instead produce a plain shifted copy. Empty rectangles and the reserved format must leave memory untouched yet still pulse done once; a design that got this wrong would either write or hang. Words offered while busy must not shift the framing of the next command.

// File: rtl/blit_pkg.sv
package blit_pkg;
    localparam int DWORD_W   = 32;
    localparam int COORD_W   = 16;
    localparam int ADDR_W    = 32;
    localparam int WADDR_W   = ADDR_W - 2;
    localparam int LANES     = DWORD_W / 8;
    localparam int CMD_WORDS = 8;

    typedef enum logic [1:0] {
        PF_8   = 2'b00,
        PF_16  = 2'b01,
        PF_RSV = 2'b10,
        PF_32  = 2'b11
    } pix_fmt_e;

    typedef struct packed {
        logic               wr_alpha;
        logic               wr_rgb;
        logic [7:0]         rop;
        pix_fmt_e           fmt;
        logic [COORD_W-1:0] dpitch;
        logic [COORD_W-1:0] dx1;
        logic [COORD_W-1:0] dy1;
        logic [COORD_W-1:0] dx2;
        logic [COORD_W-1:0] dy2;
        logic [ADDR_W-1:0]  dbase;
        logic [COORD_W-1:0] sx;
        logic [COORD_W-1:0] sy;
        logic [COORD_W-1:0] spitch;
        logic [ADDR_W-1:0]  sbase;
    } blit_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RD_SRC,
        ST_RD_DST,
        ST_WRITE,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/blit_cmd_rx.sv
module blit_cmd_rx
    import blit_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cmd_valid_i,
    input  logic [DWORD_W-1:0] cmd_data_i,
    input  logic               busy_i,
    output logic               cmd_ready_o,
    output blit_cmd_t          cmd_o,
    output logic               go_o
);
    localparam int CNT_W = $clog2(CMD_WORDS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        blit_cmd_t        cmd;
        logic             go;
    } rx_t;

    rx_t r_q, r_d;

    assign cmd_ready_o = !busy_i;

    always_comb begin
        r_d    = r_q;
        r_d.go = 1'b0;
        if (cmd_valid_i && !busy_i) begin
            case (int'(r_q.cnt))
                0: begin
                    r_d.cmd.wr_alpha = cmd_data_i[1];
                    r_d.cmd.wr_rgb   = cmd_data_i[0];
                end
                1: begin
                    r_d.cmd.fmt    = pix_fmt_e'(cmd_data_i[25:24]);
                    r_d.cmd.rop    = cmd_data_i[23:16];
                    r_d.cmd.dpitch = cmd_data_i[15:0];
                end
                2: begin
                    r_d.cmd.dy1 = cmd_data_i[31:16];
                    r_d.cmd.dx1 = cmd_data_i[15:0];
                end
                3: begin
                    r_d.cmd.dy2 = cmd_data_i[31:16];
                    r_d.cmd.dx2 = cmd_data_i[15:0];
                end
                4: r_d.cmd.dbase = cmd_data_i;
                5: begin
                    r_d.cmd.sy = cmd_data_i[31:16];
                    r_d.cmd.sx = cmd_data_i[15:0];
                end
                6: r_d.cmd.spitch = cmd_data_i[15:0];
                default: r_d.cmd.sbase = cmd_data_i;
            endcase
            if (int'(r_q.cnt) == CMD_WORDS - 1) begin
                r_d.cnt = '0;
                r_d.go  = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign cmd_o = r_q.cmd;
    assign go_o  = r_q.go;

    // R1: a new command never launches while the previous one still holds the port
    a_r1_go_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_o |-> $past(cmd_ready_o));
endmodule

// File: rtl/blit_pix_merge.sv
module blit_pix_merge
    import blit_pkg::*;
(
    input  pix_fmt_e           fmt_i,
    input  logic [7:0]         rop_i,
    input  logic               wr_alpha_i,
    input  logic               wr_rgb_i,
    input  logic [DWORD_W-1:0] src_word_i,
    input  logic [1:0]         src_lane_i,
    input  logic [DWORD_W-1:0] dst_word_i,
    input  logic [1:0]         dst_lane_i,
    output logic [DWORD_W-1:0] wdata_o,
    output logic [LANES-1:0]   be_o
);
    logic [7:0]         s8;
    logic [15:0]        s16;
    logic [DWORD_W-1:0] src_rep;

    always_comb begin
        s8  = src_word_i[8*src_lane_i +: 8];
        s16 = src_word_i[16*src_lane_i[1] +: 16];
        case (fmt_i)
            PF_8: begin
                src_rep = {LANES{s8}};
                be_o    = LANES'(1) << dst_lane_i;
            end
            PF_16: begin
                src_rep = {(LANES/2){s16}};
                be_o    = LANES'(3) << (2 * dst_lane_i[1]);
            end
            PF_32: begin
                src_rep = src_word_i;
                be_o    = {wr_alpha_i, {(LANES-1){wr_rgb_i}}};
            end
            default: begin
                src_rep = src_word_i;
                be_o    = '0;
            end
        endcase
    end

    for (genvar b = 0; b < DWORD_W; b++) begin : g_rop
        assign wdata_o[b] = rop_i[{1'b1, src_rep[b], dst_word_i[b]}];
    end
endmodule

// File: rtl/blit_seq.sv
module blit_seq
    import blit_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               go_i,
    input  blit_cmd_t          cmd_i,
    input  logic [DWORD_W-1:0] mem_rdata_i,
    output logic [WADDR_W-1:0] mem_addr_o,
    output logic               mem_rd_o,
    output logic               mem_wr_o,
    output logic [1:0]         src_lane_o,
    output logic [1:0]         dst_lane_o,
    output logic [DWORD_W-1:0] src_word_o,
    output logic               busy_o,
    output logic               done_o
);
    typedef struct packed {
        seq_state_e         state;
        logic [COORD_W-1:0] cx;
        logic [COORD_W-1:0] ry;
        logic [COORD_W-1:0] width;
        logic [COORD_W-1:0] height;
        logic [ADDR_W-1:0]  drow;
        logic [ADDR_W-1:0]  srow;
        logic [DWORD_W-1:0] sword;
    } seq_t;

    seq_t s_q, s_d;

    logic [1:0]        shift;
    logic [ADDR_W-1:0] dpitch_a, spitch_a, dbase_a, sbase_a;
    logic [ADDR_W-1:0] doff, soff, dbyte, sbyte;
    logic              rect_ok;
    logic              unused_bits;

    assign unused_bits = ^{cmd_i.rop, cmd_i.wr_alpha, cmd_i.wr_rgb,
                           cmd_i.dpitch[1:0], cmd_i.spitch[1:0],
                           cmd_i.dbase[1:0], cmd_i.sbase[1:0]};

    always_comb begin
        case (cmd_i.fmt)
            PF_8:    shift = 2'd0;
            PF_16:   shift = 2'd1;
            default: shift = 2'd2;
        endcase
        dpitch_a = ADDR_W'({cmd_i.dpitch[COORD_W-1:2], 2'b00});
        spitch_a = ADDR_W'({cmd_i.spitch[COORD_W-1:2], 2'b00});
        dbase_a  = {cmd_i.dbase[ADDR_W-1:2], 2'b00};
        sbase_a  = {cmd_i.sbase[ADDR_W-1:2], 2'b00};
        doff     = ADDR_W'(COORD_W'(cmd_i.dx1 + s_q.cx)) << shift;
        soff     = ADDR_W'(COORD_W'(cmd_i.sx + s_q.cx)) << shift;
        dbyte    = s_q.drow + doff;
        sbyte    = s_q.srow + soff;
        rect_ok  = (cmd_i.dx2 > cmd_i.dx1) && (cmd_i.dy2 > cmd_i.dy1)
                   && (cmd_i.fmt != PF_RSV);
    end

    always_comb begin
        s_d = s_q;
        case (s_q.state)
            ST_IDLE: if (go_i) s_d.state = ST_SETUP;
            ST_SETUP: begin
                s_d.cx     = '0;
                s_d.ry     = '0;
                s_d.width  = cmd_i.dx2 - cmd_i.dx1;
                s_d.height = cmd_i.dy2 - cmd_i.dy1;
                s_d.drow   = dbase_a + ADDR_W'(ADDR_W'(cmd_i.dy1) * dpitch_a);
                s_d.srow   = sbase_a + ADDR_W'(ADDR_W'(cmd_i.sy) * spitch_a);
                s_d.state  = rect_ok ? ST_RD_SRC : ST_DONE;
            end
            ST_RD_SRC: s_d.state = ST_RD_DST;
            ST_RD_DST: begin
                s_d.sword = mem_rdata_i;
                s_d.state = ST_WRITE;
            end
            ST_WRITE: begin
                if (s_q.cx + 1'b1 == s_q.width) begin
                    s_d.cx = '0;
                    if (s_q.ry + 1'b1 == s_q.height) begin
                        s_d.state = ST_DONE;
                    end else begin
                        s_d.ry    = s_q.ry + 1'b1;
                        s_d.drow  = s_q.drow + dpitch_a;
                        s_d.srow  = s_q.srow + spitch_a;
                        s_d.state = ST_RD_SRC;
                    end
                end else begin
                    s_d.cx    = s_q.cx + 1'b1;
                    s_d.state = ST_RD_SRC;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign mem_rd_o   = (s_q.state == ST_RD_SRC) || (s_q.state == ST_RD_DST);
    assign mem_wr_o   = (s_q.state == ST_WRITE);
    assign mem_addr_o = (s_q.state == ST_RD_SRC) ? sbyte[ADDR_W-1:2] : dbyte[ADDR_W-1:2];
    assign src_lane_o = sbyte[1:0];
    assign dst_lane_o = dbyte[1:0];
    assign src_word_o = s_q.sword;
    assign busy_o     = (s_q.state != ST_IDLE);
    assign done_o     = (s_q.state == ST_DONE);

    // R1: a launch request only arrives while the walker is idle
    a_r1_go_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_i |-> (s_q.state == ST_IDLE));
    // R2: every write falls inside the rectangle size latched at setup
    a_r2_write_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_wr_o |-> (s_q.cx < s_q.width) && (s_q.ry < s_q.height));
    // R9: a write is always preceded by the destination read of the same pixel
    a_r9_read_before_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_wr_o |-> $past(mem_rd_o) && $stable(mem_addr_o));
endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cmd_valid_i,
    input  logic [DWORD_W-1:0] cmd_data_i,
    output logic               cmd_ready_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [WADDR_W-1:0] mem_addr_o,
    output logic               mem_rd_o,
    output logic               mem_wr_o,
    output logic [DWORD_W-1:0] mem_wdata_o,
    output logic [LANES-1:0]   mem_be_o,
    input  logic [DWORD_W-1:0] mem_rdata_i
);
    blit_cmd_t          cmd;
    logic               go, seq_busy;
    logic [1:0]         src_lane, dst_lane;
    logic [DWORD_W-1:0] src_word;

    assign busy_o = go || seq_busy;

    blit_cmd_rx u_rx (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_valid_i (cmd_valid_i),
        .cmd_data_i  (cmd_data_i),
        .busy_i      (busy_o),
        .cmd_ready_o (cmd_ready_o),
        .cmd_o       (cmd),
        .go_o        (go)
    );

    blit_seq u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .go_i        (go),
        .cmd_i       (cmd),
        .mem_rdata_i (mem_rdata_i),
        .mem_addr_o  (mem_addr_o),
        .mem_rd_o    (mem_rd_o),
        .mem_wr_o    (mem_wr_o),
        .src_lane_o  (src_lane),
        .dst_lane_o  (dst_lane),
        .src_word_o  (src_word),
        .busy_o      (seq_busy),
        .done_o      (done_o)
    );

    blit_pix_merge u_merge (
        .fmt_i      (cmd.fmt),
        .rop_i      (cmd.rop),
        .wr_alpha_i (cmd.wr_alpha),
        .wr_rgb_i   (cmd.wr_rgb),
        .src_word_i (src_word),
        .src_lane_i (src_lane),
        .dst_word_i (mem_rdata_i),
        .dst_lane_i (dst_lane),
        .wdata_o    (mem_wdata_o),
        .be_o       (mem_be_o)
    );

    // R1: done is a single-cycle pulse and the input reopens right after it
    a_r1_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o && cmd_ready_o);
    // R1: the memory port never reads and writes in the same cycle
    a_r1_rdwr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_rd_o && mem_wr_o));
    // R4: byte-wide pixels enable exactly one lane
    a_r4_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_wr_o && cmd.fmt == PF_8) |-> ($countones(mem_be_o) == 1));
    // R5: half-word pixels enable exactly two lanes
    a_r5_two_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_wr_o && cmd.fmt == PF_16) |-> ($countones(mem_be_o) == 2));
    // R10: the reserved format never reaches the write port
    a_r10_rsv_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_wr_o |-> (cmd.fmt != PF_RSV));
endmodule

// File: tb/blit_engine_bench.sv
`timescale 1ns/100ps
module blit_engine_bench;
    localparam int MEM_WORDS = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        cmd_ready, busy, done;
    logic [29:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    logic [31:0] mem [MEM_WORDS];
    logic [31:0] ref_mem [MEM_WORDS];
    logic        fill_req = 1'b0;
    logic [31:0] fill_seed = '0;
    logic [31:0] cmdw [8];

    int checks = 0;
    int failures = 0;
    int n_wr, first_wa, last_wa;

    always #2.5 clk = ~clk;

    blit_engine u_blit_engine (
        .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_data_i(cmd_data),
        .cmd_ready_o(cmd_ready), .busy_o(busy), .done_o(done),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_rdata_i(mem_rdata)
    );

    function automatic logic [31:0] pat(int i, logic [31:0] seed);
        return (32'(i) * 32'h9E3779B1) ^ (seed * 32'h7F4A7C15) ^ (32'(i) << 13);
    endfunction

    always_ff @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < MEM_WORDS; i++) mem[i] <= pat(i, fill_seed);
        end else if (mem_wr) begin
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem[mem_addr[8:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
        end
        if (mem_rd) mem_rdata <= mem[mem_addr[8:0]];
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic do_fill(input logic [31:0] seed);
        @(negedge clk);
        fill_seed = seed;
        fill_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0;
        for (int i = 0; i < MEM_WORDS; i++) ref_mem[i] = pat(i, seed);
    endtask

    function automatic logic [7:0] rb(int a);
        return ref_mem[(a >> 2) % MEM_WORDS][8*(a & 3) +: 8];
    endfunction

    // Reference behaviour written from the requirements, byte by byte
    function automatic int model_run();
        int fmt, bpp, dp, sp, x1, y1, x2, y2, db, sb, sx, sy, da, sa;
        logic [7:0] rop, s, d, r;
        fmt = int'(cmdw[1][25:24]);
        rop = cmdw[1][23:16];
        dp  = int'(cmdw[1][15:0]) & ~3;
        sp  = int'(cmdw[6][15:0]) & ~3;
        x1 = int'(cmdw[2][15:0]); y1 = int'(cmdw[2][31:16]);
        x2 = int'(cmdw[3][15:0]); y2 = int'(cmdw[3][31:16]);
        sx = int'(cmdw[5][15:0]); sy = int'(cmdw[5][31:16]);
        db = int'(cmdw[4]) & ~3;  sb = int'(cmdw[7]) & ~3;
        bpp = (fmt == 0) ? 1 : (fmt == 1) ? 2 : 4;
        if (fmt == 2 || x2 <= x1 || y2 <= y1) return 0;
        for (int row = 0; row < y2 - y1; row++) begin
            for (int col = 0; col < x2 - x1; col++) begin
                sa = sb + (sy + row) * sp + (sx + col) * bpp;
                da = db + (y1 + row) * dp + (x1 + col) * bpp;
                for (int k = 0; k < bpp; k++) begin
                    s = rb(sa + k);
                    d = rb(da + k);
                    for (int b = 0; b < 8; b++) r[b] = rop[{1'b1, s[b], d[b]}];
                    if (bpp != 4 || (k == 3 ? cmdw[0][1] : cmdw[0][0]))
                        ref_mem[((da + k) >> 2) % MEM_WORDS][8*((da + k) & 3) +: 8] = r;
                end
            end
        end
        return (x2 - x1) * (y2 - y1);
    endfunction

    task automatic set_cmd(input logic [1:0] flags, input logic [1:0] fmt, input logic [7:0] rop,
                           input logic [15:0] dp, input logic [15:0] x1, input logic [15:0] y1,
                           input logic [15:0] x2, input logic [15:0] y2, input logic [31:0] db,
                           input logic [15:0] sx, input logic [15:0] sy, input logic [15:0] sp,
                           input logic [31:0] sb);
        cmdw[0] = {30'h0, flags};
        cmdw[1] = {6'h0, fmt, rop, dp};
        cmdw[2] = {y1, x1};
        cmdw[3] = {y2, x2};
        cmdw[4] = db;
        cmdw[5] = {sy, sx};
        cmdw[6] = {16'h0, sp};
        cmdw[7] = sb;
    endtask

    task automatic exec(input string tag, input bit junk);
        int exp_w, mis, ready_hi;
        exp_w = model_run();
        n_wr = 0; first_wa = -1; last_wa = -1; ready_hi = 0;
        for (int i = 0; i < 8; i++) begin
            cmd_valid = 1'b1;
            cmd_data = cmdw[i];
            @(negedge clk);
        end
        chk(cmd_ready == 1'b0 && busy == 1'b1, {tag, " R1 held off after last word"}, cmd_ready, 0);
        cmd_valid = junk;
        cmd_data = 32'hDEAD_BEEF;
        while (!done) begin
            if (cmd_ready) ready_hi++;
            if (mem_wr) begin
                if (first_wa < 0) first_wa = int'(mem_addr);
                last_wa = int'(mem_addr);
                n_wr++;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk(ready_hi == 0, {tag, " R1 ready low while busy"}, ready_hi, 0);
        @(negedge clk);
        chk(done == 1'b0 && cmd_ready == 1'b1, {tag, " R1 done one cycle then ready"}, {done, cmd_ready}, 2'b01);
        chk(n_wr == exp_w, {tag, " R2 write count"}, n_wr, exp_w);
        mis = 0;
        for (int i = 0; i < MEM_WORDS; i++) if (mem[i] !== ref_mem[i]) mis++;
        chk(mis == 0, {tag, " memory image mismatched words"}, mis, 0);
    endtask

    task automatic t_reset();
        chk(cmd_ready && !busy && !done && !mem_wr && !mem_rd, "R1 reset state",
            {cmd_ready, busy, done, mem_wr, mem_rd}, 5'b10000);
    endtask

    task automatic t_copy32();
        do_fill(32'h11);
        set_cmd(2'b11, 2'd3, 8'hCC, 16'd64, 16'd2, 16'd1, 16'd6, 16'd4, 32'h400,
                16'd1, 16'd2, 16'd64, 32'h0);
        exec("R3 copy32", 1'b1);
        chk(first_wa == 274, "R9 first write top-left", first_wa, 274);
        chk(last_wa == 309, "R9 last write bottom-right", last_wa, 309);
    endtask

    task automatic t_rops();
        logic [7:0] ops [4] = '{8'h00, 8'hFF, 8'h55, 8'h66};
        foreach (ops[i]) begin
            do_fill(32'h20 + i);
            set_cmd(2'b11, 2'd3, ops[i], 16'd32, 16'd0, 16'd0, 16'd3, 16'd2, 32'h300,
                    16'd4, 16'd1, 16'd32, 32'h40);
            exec($sformatf("R3 rop %02h", ops[i]), 1'b0);
        end
    endtask

    task automatic t_8bpp();
        do_fill(32'h31);
        set_cmd(2'b00, 2'd0, 8'hCC, 16'd32, 16'd3, 16'd2, 16'd10, 16'd4, 32'h600,
                16'd1, 16'd0, 16'd40, 32'h100);
        exec("R4 8bpp copy", 1'b0);
    endtask

    task automatic t_16bpp();
        do_fill(32'h41);
        set_cmd(2'b00, 2'd1, 8'h66, 16'd32, 16'd1, 16'd0, 16'd6, 16'd3, 32'h500,
                16'd2, 16'd1, 16'd36, 32'h80);
        exec("R5 16bpp xor", 1'b0);
    endtask

    task automatic t_masks();
        do_fill(32'h51);
        set_cmd(2'b10, 2'd3, 8'hCC, 16'd64, 16'd0, 16'd0, 16'd4, 16'd2, 32'h400,
                16'd0, 16'd0, 16'd64, 32'h0);
        exec("R6 alpha only", 1'b0);
        do_fill(32'h52);
        set_cmd(2'b01, 2'd3, 8'hCC, 16'd64, 16'd0, 16'd0, 16'd4, 16'd2, 32'h400,
                16'd0, 16'd0, 16'd64, 32'h0);
        exec("R6 rgb only", 1'b0);
    endtask

    task automatic t_empty();
        do_fill(32'h61);
        set_cmd(2'b11, 2'd3, 8'hFF, 16'd64, 16'd5, 16'd1, 16'd5, 16'd4, 32'h400,
                16'd0, 16'd0, 16'd64, 32'h0);
        exec("R7 zero width", 1'b0);
        set_cmd(2'b11, 2'd3, 8'hFF, 16'd64, 16'd1, 16'd6, 16'd4, 16'd2, 32'h400,
                16'd0, 16'd0, 16'd64, 32'h0);
        exec("R7 inverted height", 1'b0);
    endtask

    task automatic t_pitch();
        do_fill(32'h71);
        set_cmd(2'b11, 2'd3, 8'hCC, 16'h0043, 16'd1, 16'd1, 16'd4, 16'd4, 32'h402,
                16'd0, 16'd1, 16'h0042, 32'h1);
        exec("R8 pitch low bits", 1'b0);
    endtask

    task automatic t_overlap();
        do_fill(32'h81);
        set_cmd(2'b11, 2'd3, 8'hCC, 16'd64, 16'd1, 16'd0, 16'd5, 16'd2, 32'h200,
                16'd0, 16'd0, 16'd64, 32'h200);
        exec("R9 overlap smear", 1'b0);
        chk(mem[(32'h200 + 16) >> 2] === pat(32'h200 >> 2, 32'h81),
            "R9 left pixel propagated", mem[(32'h200 + 16) >> 2], pat(32'h200 >> 2, 32'h81));
    endtask

    task automatic t_reserved();
        do_fill(32'h91);
        set_cmd(2'b11, 2'd2, 8'hFF, 16'd64, 16'd0, 16'd0, 16'd4, 16'd4, 32'h400,
                16'd0, 16'd0, 16'd64, 32'h0);
        exec("R10 reserved format", 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_copy32();
        t_rops();
        t_8bpp();
        t_16bpp();
        t_masks();
        t_empty();
        t_pitch();
        t_overlap();
        t_reserved();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule